// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block finds the vertical sync interval in a digitized video stream and reports the field parity. A slicer upstream supplies one flag per sample that is high while the signal sits at sync-tip level, plus a strobe on the first sample of every line. A saturating low-time counter adds up sync-tip samples across every kind of sync pulse: horizontal, equalizing, serration and broad. It is cleared only when the signal stays above sync for longer than a programmable gap. When the sum first exceeds a programmable threshold, the vertical sync output and the field flag change in that same cycle. The field flag is taken from whether the detection fell in the first or the second half of the current line.

Vertical sync then stays high for a programmable number of line strobes and cannot fire again until the counter has returned to zero. A line watchdog looks for a detection in every window of `WD_LINES` (337) line strobes. Each window that ends without a detection toggles the field flag, so that field timing keeps running through lost sync. After one missed window, or three in a row when the control bit asks for it, the block declares loss of vertical lock and issues a one-cycle request for the timing loops to go back to acquisition.

The control state machine has three states. SEARCH waits for the count to exceed the threshold (transition *detect*, SEARCH→ACTIVE). ACTIVE holds vertical sync high until the programmed number of line strobes has been seen (transition *expire*, ACTIVE→HOLDOFF). HOLDOFF waits for the low-time counter to clear (transition *rearm*, HOLDOFF→SEARCH). Reset enters SEARCH.

Top module: `vsync_field_det`

## Requirements
- R1: The low-time count grows by one on every sample with `sync_tip`=1 and keeps its value across runs of up to `gap_max` consecutive samples with `sync_tip`=0. On the (`gap_max`+1)-th consecutive such sample it clears to 0. Lines that carry only short horizontal pulses therefore never produce vertical sync.
- R2: In SEARCH, `vsync` goes high in the cycle after the sample that takes the count strictly above `detect_thresh`. A count equal to the threshold does not assert it.
- R3: `field` takes its new value in the same cycle that `vsync` rises. The value is 0 (odd) if the crossing sample lies at a line position below `samples_per_line`/2, counted from 0 at the strobe sample, and 1 (even) otherwise. It is then held.
- R4: `vsync` stays high until the `vs_lines`-th line strobe after detection (a setting of 0 acts as 1) and falls in the following cycle. It does not rise again until the low-time count has been 0.
- R5: The low-time count saturates at its all-ones value and never wraps to zero during a long sync-tip run.
- R6: `vs_lost` rises when `WD_LINES` line strobes pass without a detection, in each of 1 successive window (`miss3_sel`=0) or 3 successive windows (`miss3_sel`=1). The window count restarts at every detection, and a detection clears `vs_lost`.
- R7: Each window of `WD_LINES` line strobes that ends without a detection inverts `field` once.
- R8: `reacquire` is a single-cycle pulse that is high exactly in the cycle in which `vs_lost` rises. It is not repeated while loss persists.
- R9: After reset, `vsync`, `field`, `vs_lost` and `reacquire` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_tip | input | 1 | Current sample is at sync-tip level |
| line_start | input | 1 | Strobe on the first sample of a line |
| samples_per_line | input | POS_W | Samples in one line |
| detect_thresh | input | LOW_W | Count that must be exceeded to detect vertical sync |
| gap_max | input | GAP_W | Longest high run that keeps the count |
| vs_lines | input | VSL_W | Line strobes for which vsync is held |
| miss3_sel | input | 1 | 0: one missed window declares loss; 1: three |
| vsync | output | 1 | Vertical sync indication |
| field | output | 1 | 0 odd field, 1 even field |
| vs_lost | output | 1 | Loss of vertical lock |
| reacquire | output | 1 | One-cycle request to restart acquisition |

## Verification
The assertions watch, on every cycle, that the low-time count never wraps and clears after an over-long gap, that a rise of vsync coincides with a count above the threshold, that field does not move while vsync is held, and that the reacquire pulse lasts one cycle and appears with, and only with, a rising loss flag. Only the bench scenarios can show the field decisions that depend on where a crossing falls in the line: broad, half-line and equalizing patterns, and the gap lengths just at and just beyond the limit. The same holds for the exact length of the vsync interval with its holdoff, the one-versus-three window selection, and the flywheel toggling across hundreds of lines.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_HOLDOFF = 2'd2
    } vfd_state_t;
endpackage

// File: rtl/vfd_low_timer.sv
// Accumulates sync-tip samples; clears after a high run longer than gap_max.
module vfd_low_timer #(
    parameter int LOW_W = 12,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_tip,
    input  logic [GAP_W-1:0] gap_max,
    output logic [LOW_W-1:0] low_cnt,
    output logic [GAP_W-1:0] high_run
);
    localparam logic [LOW_W-1:0] LOW_MAX = '1;
    localparam logic [GAP_W-1:0] GAP_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_run <= '0;
        end else if (sync_tip) begin
            high_run <= '0;
            if (low_cnt != LOW_MAX)
                low_cnt <= low_cnt + LOW_W'(1);
        end else begin
            if (high_run != GAP_TOP)
                high_run <= high_run + GAP_W'(1);
            if (high_run >= gap_max)
                low_cnt <= '0;
        end
    end
endmodule

// File: rtl/vfd_line_pos.sv
// Position inside the line; flags the second half.
module vfd_line_pos #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [POS_W-1:0] samples_per_line,
    output logic             second_half
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (line_start)
            pos_q <= '0;
        else if (pos_q != POS_MAX)
            pos_q <= pos_q + POS_W'(1);
    end

    // pos_q lags the sample stream by one, matching the registered low count
    assign second_half = (pos_q >= (samples_per_line >> 1));
endmodule

// File: rtl/vfd_miss_watch.sv
// Line watchdog: flywheel toggle per missed window, loss and reacquire.
module vfd_miss_watch #(
    parameter int WD_LINES = 337
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic det,
    input  logic miss3_sel,
    output logic flip,
    output logic lost,
    output logic reacq
);
    localparam int LC_W = $clog2(WD_LINES + 1);
    localparam logic [LC_W-1:0] LC_END = LC_W'(WD_LINES - 1);

    logic [LC_W-1:0] lc_q;
    logic [1:0]      miss_q;
    logic [1:0]      miss_nxt;
    logic [1:0]      need;
    logic            win_end;

    assign win_end  = line_start && (lc_q == LC_END);
    assign miss_nxt = (miss_q == 2'd3) ? 2'd3 : miss_q + 2'd1;
    assign need     = miss3_sel ? 2'd3 : 2'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_q   <= '0;
            miss_q <= '0;
            lost   <= 1'b0;
            flip   <= 1'b0;
            reacq  <= 1'b0;
        end else begin
            flip  <= 1'b0;
            reacq <= 1'b0;
            if (det) begin
                lc_q   <= '0;
                miss_q <= '0;
                lost   <= 1'b0;
            end else if (win_end) begin
                lc_q   <= '0;
                miss_q <= miss_nxt;
                flip   <= 1'b1;
                if (!lost && (miss_nxt >= need)) begin
                    lost  <= 1'b1;
                    reacq <= 1'b1;
                end
            end else if (line_start) begin
                lc_q <= lc_q + LC_W'(1);
            end
        end
    end
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det
    import vfd_pkg::*;
#(
    parameter int POS_W    = 12,
    parameter int LOW_W    = 12,
    parameter int GAP_W    = 8,
    parameter int VSL_W    = 4,
    parameter int WD_LINES = 337
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_tip,
    input  logic             line_start,
    input  logic [POS_W-1:0] samples_per_line,
    input  logic [LOW_W-1:0] detect_thresh,
    input  logic [GAP_W-1:0] gap_max,
    input  logic [VSL_W-1:0] vs_lines,
    input  logic             miss3_sel,
    output logic             vsync,
    output logic             field,
    output logic             vs_lost,
    output logic             reacquire
);
    localparam int VC_W = VSL_W + 1;

    vfd_state_t       st_q, st_nxt;
    logic [LOW_W-1:0] low_cnt;
    logic [GAP_W-1:0] high_run;
    logic             second_half;
    logic             over, low_zero, det, flip, vs_done;
    logic             field_q;
    logic [VSL_W-1:0] vs_cnt;
    logic [VC_W-1:0]  vs_len_eff;

    vfd_low_timer #(.LOW_W(LOW_W), .GAP_W(GAP_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_tip (sync_tip),
        .gap_max  (gap_max),
        .low_cnt  (low_cnt),
        .high_run (high_run)
    );

    vfd_line_pos #(.POS_W(POS_W)) pos_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .line_start       (line_start),
        .samples_per_line (samples_per_line),
        .second_half      (second_half)
    );

    vfd_miss_watch #(.WD_LINES(WD_LINES)) watch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .det        (det),
        .miss3_sel  (miss3_sel),
        .flip       (flip),
        .lost       (vs_lost),
        .reacq      (reacquire)
    );

    assign over       = (low_cnt > detect_thresh);
    assign low_zero   = (low_cnt == '0);
    assign det        = (st_q == ST_SEARCH) && over;
    assign vs_len_eff = (vs_lines == '0) ? VC_W'(1) : {1'b0, vs_lines};
    assign vs_done    = line_start && (({1'b0, vs_cnt} + VC_W'(1)) >= vs_len_eff);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SEARCH;
        else        st_q <= st_nxt;
    end

    // transitions: detect, expire, rearm
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_SEARCH:  if (over)     st_nxt = ST_ACTIVE;
            ST_ACTIVE:  if (vs_done)  st_nxt = ST_HOLDOFF;
            ST_HOLDOFF: if (low_zero) st_nxt = ST_SEARCH;
            default:                  st_nxt = ST_SEARCH;
        endcase
    end

    // line count in ACTIVE and held field parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_cnt  <= '0;
            field_q <= 1'b0;
        end else begin
            if (det)
                vs_cnt <= '0;
            else if ((st_q == ST_ACTIVE) && line_start)
                vs_cnt <= vs_cnt + VSL_W'(1);
            if (det)
                field_q <= second_half;
            else if (flip)
                field_q <= ~field_q;
        end
    end

    // outputs
    always_comb begin
        vsync = 1'b0;
        field = field_q;
        unique case (st_q)
            ST_SEARCH: begin
                vsync = over;
                if (over) field = second_half;
            end
            ST_ACTIVE:  vsync = 1'b1;
            ST_HOLDOFF: vsync = 1'b0;
            default:    vsync = 1'b0;
        endcase
    end
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
    parameter int LOW_W = 12,
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_tip,
    input logic [GAP_W-1:0] gap_max,
    input logic [LOW_W-1:0] detect_thresh,
    input logic [LOW_W-1:0] low_q,
    input logic [GAP_W-1:0] high_run,
    input logic             vsync,
    input logic             field,
    input logic             vs_lost,
    input logic             reacquire
);
    localparam logic [LOW_W-1:0] LOW_MAX = '1;

    p_gap_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_tip && high_run >= gap_max) |=> (low_q == '0));

    p_rise_over_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (low_q > detect_thresh));

    p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && $past(vsync)) |-> $stable(field));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_tip && low_q == LOW_MAX) |=> (low_q == LOW_MAX));

    p_lost_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_lost) |-> $past(vsync));

    p_reacq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reacquire |=> !reacquire);

    p_reacq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_lost) |-> reacquire);

    p_reacq_with_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reacquire |-> (vs_lost && !$past(vs_lost)));
endmodule

bind vsync_field_det vfd_checker #(.LOW_W(LOW_W), .GAP_W(GAP_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_tip      (sync_tip),
    .gap_max       (gap_max),
    .detect_thresh (detect_thresh),
    .low_q         (low_cnt),
    .high_run      (high_run),
    .vsync         (vsync),
    .field         (field),
    .vs_lost       (vs_lost),
    .reacquire     (reacquire)
);

// File: tb/vsync_field_det_tb_top.sv
module vsync_field_det_tb_top;
    localparam int L     = 64;
    localparam int WD    = 337;
    localparam int K_NORM = 0, K_BROAD = 1, K_HALF = 2, K_EQ = 3,
                   K_P20 = 4, K_GAP11 = 6, K_GAP10 = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_tip = 1'b0;
    logic        line_start = 1'b0;
    logic [11:0] samples_per_line = 12'(L);
    logic [11:0] detect_thresh = 12'd20;
    logic [7:0]  gap_max = 8'd10;
    logic [3:0]  vs_lines = 4'd3;
    logic        miss3_sel = 1'b0;
    logic        vsync, field, vs_lost, reacquire;

    int total = 0, bad = 0, rises = 0, reacq_cyc = 0;
    logic prev_vs = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    vsync_field_det dut_i (
        .clk(clk), .rst_n(rst_n), .sync_tip(sync_tip), .line_start(line_start),
        .samples_per_line(samples_per_line), .detect_thresh(detect_thresh),
        .gap_max(gap_max), .vs_lines(vs_lines), .miss3_sel(miss3_sel),
        .vsync(vsync), .field(field), .vs_lost(vs_lost), .reacquire(reacquire)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (vsync && !prev_vs) rises <= rises + 1;
            if (reacquire) reacq_cyc <= reacq_cyc + 1;
        end
        prev_vs <= vsync;
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic pat(input int kind, input int p);
        case (kind)
            K_NORM:  return p < 5;
            K_BROAD: return (p < 28) || (p >= 32 && p < 60);
            K_HALF:  return (p < 5) || (p >= 32 && p < 60);
            K_EQ:    return (p % 8) < 3;
            K_P20:   return p < 20;
            K_GAP11: return (p < 12) || (p >= 23 && p < 35);
            K_GAP10: return (p < 12) || (p >= 22 && p < 34);
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input logic s, input logic ls);
        @(negedge clk);
        sync_tip   = s;
        line_start = ls;
    endtask

    task automatic line(input int kind);
        for (int p = 0; p < L; p++) step(pat(kind, p), p == 0);
    endtask

    task automatic lines(input int kind, input int n);
        for (int i = 0; i < n; i++) line(kind);
    endtask

    task automatic t_reset;
        chk("R9 vsync after reset", vsync, 0);
        chk("R9 field after reset", field, 0);
        chk("R9 vs_lost after reset", vs_lost, 0);
        chk("R9 reacquire after reset", reacquire, 0);
    endtask

    task automatic t_hsync_only;
        int r0 = rises;
        lines(K_NORM, 20);
        chk("R1 horizontal pulses never detect", rises, r0);
        lines(K_GAP11, 3);
        chk("R1 gap of gap_max+1 clears count", rises, r0);
        lines(K_NORM, 2);
    endtask

    task automatic t_field(input string tag, input int kind, input int exp_field);
        int r0 = rises;
        line(kind);
        chk({tag, " detection happened"}, rises, r0 + 1);
        chk({tag, " field parity"}, field, exp_field);
        lines(K_NORM, 4);
        chk({tag, " vsync released"}, vsync, 0);
    endtask

    task automatic t_thresh_exact;
        int r0 = rises;
        line(K_P20);
        chk("R2 count equal to threshold does not detect", rises, r0);
        lines(K_NORM, 1);
        for (int i = 0; i <= 20; i++) begin
            step(1'b1, i == 0);
            if (i == 20) chk("R2 vsync low at count 20", vsync, 0);
        end
        step(1'b0, 1'b0);
        chk("R2 vsync high at count 21", vsync, 1);
        chk("R3 field same cycle first half", field, 0);
        for (int p = 22; p < L; p++) step(1'b0, 1'b0);
        lines(K_NORM, 4);
    endtask

    task automatic t_hold;
        int r0 = rises;
        line(K_BROAD);
        lines(K_BROAD, 2);
        chk("R4 vsync held before 3rd strobe", vsync, 1);
        line(K_BROAD);
        chk("R4 vsync dropped after 3rd strobe", vsync, 0);
        lines(K_BROAD, 2);
        chk("R4 no retrigger before count clears", rises, r0 + 1);
        lines(K_NORM, 2);
        line(K_BROAD);
        chk("R4 retrigger after clear", rises, r0 + 2);
        lines(K_NORM, 4);
    endtask

    task automatic t_saturate;
        int r0 = rises;
        for (int i = 0; i < 5000; i++) step(1'b1, (i % L) == 0);
        chk("R5 long sync-tip run gives one detection", rises, r0 + 1);
        chk("R5 no rearm during long run", vsync, 0);
        lines(K_NORM, 3);
        line(K_BROAD);
        chk("R5 detection after run ends", rises, r0 + 2);
        lines(K_NORM, 4);
    endtask

    task automatic t_miss1;
        int q0;
        miss3_sel = 1'b0;
        line(K_BROAD);
        chk("R3 broad detect odd", field, 0);
        q0 = reacq_cyc;
        lines(K_NORM, WD - 2);
        chk("R6 not lost before window end", vs_lost, 0);
        lines(K_NORM, 3);
        chk("R6 lost after one missed window", vs_lost, 1);
        chk("R8 one reacquire cycle", reacq_cyc, q0 + 1);
        chk("R7 field toggled by flywheel", field, 1);
        lines(K_NORM, WD);
        chk("R7 field toggled again", field, 0);
        chk("R8 no repeated reacquire", reacq_cyc, q0 + 1);
        line(K_BROAD);
        chk("R6 detection clears loss", vs_lost, 0);
        lines(K_NORM, 4);
    endtask

    task automatic t_miss3;
        int q0;
        miss3_sel = 1'b1;
        line(K_BROAD);
        chk("R3 broad detect odd (3-window)", field, 0);
        q0 = reacq_cyc;
        lines(K_NORM, WD + 3);
        chk("R6 3-window mode not lost after one", vs_lost, 0);
        chk("R7 field toggled after first miss", field, 1);
        lines(K_NORM, WD);
        chk("R6 3-window mode not lost after two", vs_lost, 0);
        chk("R7 field toggled after second miss", field, 0);
        lines(K_NORM, WD);
        chk("R6 lost after three windows", vs_lost, 1);
        chk("R7 field toggled after third miss", field, 1);
        chk("R8 reacquire once in 3-window mode", reacq_cyc, q0 + 1);
        line(K_BROAD);
        chk("R6 detection clears loss (3-window)", vs_lost, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hsync_only();
        t_field("R3 broad", K_BROAD, 0);
        t_field("R3 half-line", K_HALF, 1);
        t_field("R1 equalizing accumulate", K_EQ, 1);
        t_field("R1 gap of gap_max kept", K_GAP10, 0);
        t_thresh_exact();
        t_hold();
        t_saturate();
        t_miss1();
        t_miss3();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule